// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a 12-key switch matrix wired as 4 rows by 3 columns. It pulls one row line low at a time and reads the column lines, which idle high through external pull-ups. A low column on the active row means the switch at that crossing is closed. The scanner then stays on that row and requires the same switch to read closed for a programmable number of clock cycles. Only after that hold does it publish the key number.

Each make is reported once, as a one-cycle strobe with the key number alongside it. The block then waits for the switch to open. The break is filtered the same way: every column must read high for the full debounce length before row scanning starts again. The debounce length is a run-time input, so one netlist covers switches that need anywhere from tens to hundreds of milliseconds.

Top module: `keypad_scanner`

## Requirements
- R1: Exactly one bit of `row_n` is low in every cycle. During and right after reset the low bit is bit 0, so `row_n` = 4'b1110.
- R2: While no key is closed, the low bit of `row_n` advances through bit 0, 1, 2, 3 and then wraps to bit 0. Each row is held for a few cycles before its columns are judged.
- R3: A closure at 1-based row r (`row_n` bit r-1) and 1-based column c (`col_n` bit c-1) is reported with `key_code` = 3*r + c - 3, which covers the values 1 to 12.
- R4: With no key closed, `key_valid` stays low and scanning continues.
- R5: A closure that opens again before `debounce_len` cycles have passed is not reported.
- R6: A key held closed for any length of time produces exactly one `key_valid` pulse.
- R7: After a report, the key must read open for `debounce_len` consecutive cycles before a new closure can be reported. A shorter opening followed by a re-close produces no report.
- R8: `key_valid` is high for single cycles only. `key_code` changes only in a cycle where `key_valid` is high and holds its value until the next report.
- R9: The delay from closure to report is at least `debounce_len` cycles and at most `debounce_len` plus one scan pass plus the synchronizer delay.
- R10: A low `rst_n` sampled on a clock edge returns the block to row 1, with `key_valid` low and `key_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| debounce_len | input | 24 | Debounce length in clock cycles, applied to both make and break |
| col_n | input | 3 | Column lines, asynchronous, pulled high, low when a key on the driven row is closed |
| row_n | output | 4 | Row drives, exactly one low at a time |
| key_code | output | 4 | Number of the last reported key, 1 to 12 |
| key_valid | output | 1 | One-cycle strobe marking a new report |

## Verification
The hardest cases to reach from the ports are the two debounce abort paths. In the first, a make disappears partway through its hold. In the second, a break is cut short by a re-close while the scanner is still parked on the reported row. Both depend on the keypad model reacting to `row_n` in the same cycle, so the bench models the matrix as combinational logic from `row_n` and a pressed-key map. It then opens and closes keys for a chosen number of cycles, each shorter or longer than `debounce_len`. Counting strobes over a long window afterwards shows whether a report leaked through.

// File: rtl/kp_pkg.sv
// Package: shared state type for the keypad scanner.
// Assumes nothing beyond being compiled before its users.
package kp_pkg;
    typedef enum logic [1:0] {
        KP_SCAN    = 2'd0,  // stepping rows, looking for a low column
        KP_MAKE    = 2'd1,  // holding on a closed key until debounce ends
        KP_BREAK   = 2'd2   // waiting for a debounced release
    } kp_state_t;
endpackage

// File: rtl/kp_col_sync.sv
// kp_col_sync: two-flop synchronizer for the column lines.
// Assumes the columns idle high, so the flops reset to all ones.
module kp_col_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Bring the asynchronous column levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '1;
            sync_out <= '1;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/kp_dwell_timer.sv
// kp_dwell_timer: counts cycles since the last clear and flags when the
// programmed length has been reached. Saturates once done.
// Assumes the length is held steady while a count is in progress.
module kp_dwell_timer #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [LEN_W-1:0] cnt;

    assign done = (cnt >= len);

    // Count up from zero after each clear; stop once the length is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/keypad_scanner.sv
// keypad_scanner: scans a NUM_ROWS x NUM_COLS switch matrix one row at a time,
// debounces the make and the break of one key, and reports each make once.
// Assumes external pull-ups on the columns and a settle time of
// SETTLE_CYCLES covering the row drive plus the two synchronizer flops.
module keypad_scanner #(
    parameter int NUM_ROWS      = 4,
    parameter int NUM_COLS      = 3,
    parameter int SETTLE_CYCLES = 4,
    parameter int LEN_W         = 24
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LEN_W-1:0]                       debounce_len,
    input  logic [NUM_COLS-1:0]                    col_n,
    output logic [NUM_ROWS-1:0]                    row_n,
    output logic [$clog2(NUM_ROWS*NUM_COLS+1)-1:0] key_code,
    output logic                                   key_valid
);
    import kp_pkg::*;

    localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int COL_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
    localparam int CODE_W = $clog2(NUM_ROWS*NUM_COLS+1);
    localparam int SET_W  = $clog2(SETTLE_CYCLES+1);

    kp_state_t        state;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] cap_col;
    logic [SET_W-1:0] settle_cnt;
    logic [NUM_COLS-1:0] col_s;
    logic [NUM_COLS-1:0] col_low;
    logic                any_low;
    logic [COL_W-1:0]    hit_col;
    logic                timer_clr;
    logic                timer_done;
    logic                settled;

    kp_col_sync #(.WIDTH(NUM_COLS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (col_n),
        .sync_out (col_s)
    );

    kp_dwell_timer #(.LEN_W(LEN_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .len   (debounce_len),
        .done  (timer_done)
    );

    assign col_low = ~col_s;
    assign any_low = |col_low;
    assign settled = (settle_cnt == SET_W'(SETTLE_CYCLES - 1));

    // Pick the lowest-numbered low column when several read low.
    always_comb begin
        hit_col = '0;
        for (int c = NUM_COLS - 1; c >= 0; c--) begin
            if (col_low[c]) hit_col = COL_W'(c);
        end
    end

    // Drive the active row low and every other row high.
    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            assign row_n[r] = (row_idx != ROW_W'(r));
        end
    endgenerate

    // Restart the dwell timer on scan, at the end of a make, and on any low column during a break.
    always_comb begin
        unique case (state)
            KP_SCAN:  timer_clr = 1'b1;
            KP_MAKE:  timer_clr = timer_done;
            KP_BREAK: timer_clr = any_low;
            default:  timer_clr = 1'b1;
        endcase
    end

    // Sequence scanning, make debounce, reporting and break debounce.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= KP_SCAN;
            row_idx    <= '0;
            cap_col    <= '0;
            settle_cnt <= '0;
            key_code   <= '0;
            key_valid  <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            unique case (state)
                KP_SCAN: begin
                    if (!settled) begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end else if (any_low) begin
                        cap_col <= hit_col;
                        state   <= KP_MAKE;
                    end else begin
                        settle_cnt <= '0;
                        row_idx    <= (row_idx == ROW_W'(NUM_ROWS - 1)) ? '0 : row_idx + 1'b1;
                    end
                end
                KP_MAKE: begin
                    if (!col_low[cap_col]) begin
                        state      <= KP_SCAN;
                        row_idx    <= '0;
                        settle_cnt <= '0;
                    end else if (timer_done) begin
                        key_code  <= CODE_W'(row_idx) * CODE_W'(NUM_COLS)
                                   + CODE_W'(cap_col) + CODE_W'(1);
                        key_valid <= 1'b1;
                        state     <= KP_BREAK;
                    end
                end
                KP_BREAK: begin
                    if (!any_low && timer_done) begin
                        state      <= KP_SCAN;
                        row_idx    <= '0;
                        settle_cnt <= '0;
                    end
                end
                default: state <= KP_SCAN;
            endcase
        end
    end
endmodule

// File: rtl/kp_scan_chk.sv
// kp_scan_chk: port-level properties of keypad_scanner, attached by bind.
// Assumes the synchronous active-low reset of the scanner.
module kp_scan_chk #(
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 3,
    parameter int CODE_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_ROWS-1:0] row_n,
    input logic [CODE_W-1:0]   key_code,
    input logic                key_valid
);
    // R1
    one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n) == 1);

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_n != $past(row_n)) |->
            ((~row_n == {~$past(row_n[NUM_ROWS-2:0]), ~$past(row_n[NUM_ROWS-1])})
             || (~row_n == NUM_ROWS'(1))));

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_code >= 1 && key_code <= CODE_W'(NUM_ROWS*NUM_COLS)));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code));
endmodule

bind keypad_scanner kp_scan_chk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .CODE_W   (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_n     (row_n),
    .key_code  (key_code),
    .key_valid (key_valid)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
    localparam int NR = 4;
    localparam int NC = 3;
    localparam int LW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] debounce_len = LW'(8);
    logic [NC-1:0] col_n;
    logic [NR-1:0] row_n;
    logic [3:0]    key_code;
    logic          key_valid;

    logic [NR*NC-1:0] pressed = '0;
    int pass_cnt = 0;
    int fail_cnt = 0;
    int vcount = 0;
    int width_err = 0;
    int cycles = 0;
    logic prev_valid = 1'b0;

    always #10 clk = ~clk;

    keypad_scanner uut (
        .clk(clk), .rst_n(rst_n), .debounce_len(debounce_len),
        .col_n(col_n), .row_n(row_n), .key_code(key_code), .key_valid(key_valid)
    );

    // Switch matrix: a column is low when a pressed key sits on a driven row.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            col_n[c] = 1'b1;
            for (int r = 0; r < NR; r++)
                if (pressed[r*NC + c] && !row_n[r]) col_n[c] = 1'b0;
        end
    end

    // Count reports and watch the strobe width.
    always @(negedge clk) begin
        if (rst_n && key_valid) vcount++;
        if (rst_n && key_valid && prev_valid) width_err++;
        prev_valid <= key_valid;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_report(input int limit, output int waited);
        int start;
        start = vcount;
        waited = 0;
        while (vcount == start && waited < limit) begin
            @(negedge clk); #1; waited++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        check(row_n == 4'b1110, "R10 row after reset", row_n, 4'b1110);
        check(key_valid == 1'b0, "R10 valid after reset", key_valid, 0);
        check(key_code == 4'd0, "R10 code after reset", key_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(row_n == 4'b1110, "R1 row 1 driven first", row_n, 4'b1110);
    endtask

    task automatic t_scan_order;
        logic [NR-1:0] seen [8];
        logic [NR-1:0] last;
        int k;
        int v0;
        logic ok;
        v0 = vcount;
        last = row_n;
        seen[0] = row_n;
        k = 1;
        for (int i = 0; i < 200 && k < 8; i++) begin
            @(negedge clk);
            if (row_n != last) begin seen[k] = row_n; k++; last = row_n; end
        end
        ok = (k == 8);
        for (int i = 0; i < 8; i++)
            if (seen[i] != ~(NR'(1) << (i % NR))) ok = 1'b0;
        check(ok, "R2 row order 1,2,3,4,1", k, 8);
        idle(300);
        check(vcount == v0, "R4 no report while idle", vcount - v0, 0);
    endtask

    task automatic t_all_codes;
        int waited;
        debounce_len = LW'(8);
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) begin
                pressed = '0;
                pressed[r*NC + c] = 1'b1;
                wait_report(200, waited);
                check(waited < 200 && key_code == 4'(3*(r+1) + (c+1) - 3),
                      "R3 key code", key_code, 3*(r+1) + (c+1) - 3);
                pressed = '0;
                idle(40);
            end
        end
    endtask

    task automatic t_short_make;
        int v0;
        debounce_len = LW'(50);
        v0 = vcount;
        pressed = '0;
        pressed[4] = 1'b1;
        idle(30);
        pressed = '0;
        idle(300);
        check(vcount == v0, "R5 short closure ignored", vcount - v0, 0);
    endtask

    task automatic t_delay;
        int waited;
        debounce_len = LW'(60);
        pressed = '0;
        pressed[7] = 1'b1;
        wait_report(400, waited);
        check(waited >= 60 && waited <= 100, "R9 make delay", waited, 60);
        check(key_code == 4'd8, "R9 code after long debounce", key_code, 8);
        pressed = '0;
        idle(150);
    endtask

    task automatic t_hold_once;
        int v0;
        debounce_len = LW'(10);
        v0 = vcount;
        pressed = '0;
        pressed[11] = 1'b1;
        idle(800);
        check(vcount - v0 == 1, "R6 single report on hold", vcount - v0, 1);
        check(key_code == 4'd12, "R6 held key code", key_code, 12);
        pressed = '0;
        idle(60);
    endtask

    task automatic t_break;
        int v0;
        int waited;
        debounce_len = LW'(30);
        v0 = vcount;
        pressed = '0;
        pressed[0] = 1'b1;
        wait_report(200, waited);
        check(vcount - v0 == 1 && key_code == 4'd1, "R7 first make", vcount - v0, 1);
        pressed = '0;
        idle(10);
        pressed[0] = 1'b1;
        idle(300);
        check(vcount - v0 == 1, "R7 short break ignored", vcount - v0, 1);
        pressed = '0;
        idle(100);
        check(key_code == 4'd1, "R8 code held after release", key_code, 1);
        pressed[2] = 1'b1;
        wait_report(200, waited);
        check(vcount - v0 == 2 && key_code == 4'd3, "R7 new make after full break", key_code, 3);
        pressed = '0;
        idle(100);
        check(width_err == 0, "R8 strobe one cycle", width_err, 0);
    endtask

    task automatic t_reset_mid;
        debounce_len = LW'(10);
        pressed = '0;
        pressed[5] = 1'b1;
        idle(80);
        rst_n = 1'b0;
        idle(2);
        check(row_n == 4'b1110 && key_code == 4'd0 && !key_valid,
              "R10 reset mid-hold", key_code, 0);
        rst_n = 1'b1;
        pressed = '0;
        idle(20);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fail_cnt++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_scan_order();
        t_all_codes();
        t_short_make();
        t_delay();
        t_hold_once();
        t_break();
        t_reset_mid();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule